// File: doc/BRIEF.md
# External Clock Sync Mode Selector

This block sits in the digital control section of a buck regulator. It watches one sampled control pin. A low level on that pin turns the converter off, a steady high level lets it run, and a square wave on it makes the converter follow an outside frequency. From the pin and the internal oscillator tick, the block works out which of these three cases applies. It then issues exactly one cycle-start pulse per switching period, taking that pulse from either the oscillator or the outside clock.

Timing is measured in system-clock cycles. A rising edge on the pin is accepted only when three things hold: the time since the previous rising edge lies in a band derived from the programmed nominal period, that time is not below a fixed absolute floor, and the high time is near half the period. The converter switches over to the outside clock only after accepted edges have been arriving for a settle interval. Until then it keeps using the oscillator. The block also raises a flag that permits pulse-skipping light-load operation, but only while it is free-running on the oscillator.

Top module: `sync_mode_sel`

## Requirements
- R1: While reset is high, and until the pin is seen high, standby_o=1, sync_active_o=0, light_load_ok_o=0 and cycle_start_o=0.
- R2: standby_o is set once the pin has been low for more than 2*N consecutive system clocks (N = nom_period_i). While in standby no cycle-start pulse is produced. A low phase shorter than that never sets standby. The first high sample clears standby.
- R3: When the pin is high and the block is not synchronized, each osc_tick_i pulse yields one cycle_start_o pulse in the following cycle.
- R4: A rising edge is accepted only if P, the number of system clocks since the previous rising edge, satisfies floor(10N/17) <= P <= floor(10N/9). This is the 0.9x to 1.7x frequency band. Edges outside the band never lead to synchronization.
- R5: A rising edge with P below ABS_MIN_PERIOD is rejected even when it lies inside the band. ABS_MIN_PERIOD is the fastest allowed external frequency expressed as a period.
- R6: A rising edge is accepted only if the preceding high time H satisfies 4P <= 10H <= 6P, which is a 40% to 60% duty cycle.
- R7: Synchronization begins at the first accepted edge that arrives at least SETTLE_CYCLES clocks after the accepted edge that opened the settle interval. Oscillator ticks keep producing pulses during the settle interval.
- R8: While synchronized, each accepted rising edge yields one cycle_start_o pulse in the following cycle, oscillator ticks are ignored, and a tick that coincides with an edge yields a single pulse.
- R9: light_load_ok_o is 1 only when the block is free-running. It drops at the first accepted edge and stays low through the settle interval and synchronization.
- R10: If the block is synchronized or settling, it returns to the oscillator and clears sync_active_o when no rising edge arrives for 2*N clocks or when a rising edge is rejected. A rejected edge gives no pulse.
- R11: Each cycle_start_o pulse lasts one clock, and two pulses are never closer than max(floor(10N/17), ABS_MIN_PERIOD) clocks. A request that would break this spacing is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_sync_i | input | 1 | Sampled level of the combined enable/clock pin |
| osc_tick_i | input | 1 | One-clock tick from the internal oscillator |
| nom_period_i | input | CNT_W | Nominal switching period in system clocks |
| cycle_start_o | output | 1 | One-clock pulse that starts a switching period |
| sync_active_o | output | 1 | Switching follows the external clock |
| standby_o | output | 1 | Converter held off |
| light_load_ok_o | output | 1 | Pulse-skipping operation is permitted |

## Verification
Two events can land in the same cycle: an oscillator tick and an accepted external edge. The bench provokes this while the block is synchronized, by driving a tick in exactly the cycle in which the pin rises. It then expects exactly one pulse, timed one cycle after that edge. The bench also places a lone tick in the middle of a synchronized period, where no pulse may appear. Before the switch-over it drives a tick during the settle interval and expects a pulse, so it can tell which source owns the pulse in each mode. Every pulse is matched against a queue of expected cycle numbers, so a doubled or misplaced pulse is reported.

// File: rtl/sms_pkg.sv
`timescale 1ns/1ps
package sms_pkg;

    // Operating modes of the selector
    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_FREE    = 2'd1,
        MODE_SETTLE  = 2'd2,
        MODE_SYNC    = 2'd3
    } mode_e;

    // Per-cycle verdict produced by the edge meter
    typedef struct packed {
        logic accepted;     // rising edge inside band, above floor, duty ok
        logic rejected;     // rising edge failing any test
        logic lost;         // no rising edge for 2*N clocks
        logic low_timeout;  // pin low for more than 2*N clocks
    } edge_info_t;

    // Shortest acceptable period: 1.7x nominal frequency, never below floor
    function automatic logic [31:0] short_limit(input logic [31:0] nom,
                                                input logic [31:0] floor_p);
        logic [31:0] v;
        v = (nom * 32'd10) / 32'd17;
        return (v < floor_p) ? floor_p : v;
    endfunction

    // Longest acceptable period: 0.9x nominal frequency
    function automatic logic [31:0] long_limit(input logic [31:0] nom);
        return (nom * 32'd10) / 32'd9;
    endfunction

    // Silence window used for sync loss and standby
    function automatic logic [31:0] silence_limit(input logic [31:0] nom);
        return nom * 32'd2;
    endfunction

    // High time between 40% and 60% of the period
    function automatic logic duty_in_range(input logic [31:0] hi,
                                           input logic [31:0] per);
        return ((hi * 32'd10) >= (per * 32'd4)) &&
               ((hi * 32'd10) <= (per * 32'd6));
    endfunction

endpackage

// File: rtl/sms_edge_meter.sv
`timescale 1ns/1ps
module sms_edge_meter
    import sms_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int ABS_MIN_PERIOD = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_i,
    input  logic [CNT_W-1:0] nom_i,
    output edge_info_t       info_o
);

    localparam int CW = CNT_W + 2;

    logic          pin_q;
    logic [CW-1:0] since_rise;
    logic [CW-1:0] hi_len;
    logic [CW-1:0] low_cnt;
    logic          have_ref;

    logic          rise;
    logic          fall;
    logic [31:0]   nom_w;
    logic [31:0]   per_w;
    logic [31:0]   hi_w;
    logic [31:0]   low_w;
    logic [31:0]   silence_w;
    logic          in_band;
    logic          duty_ok;
    logic          lost;

    assign rise      = pin_i & ~pin_q;
    assign fall      = ~pin_i & pin_q;
    assign nom_w     = 32'(nom_i);
    assign per_w     = 32'(since_rise);
    assign hi_w      = 32'(hi_len);
    assign low_w     = 32'(low_cnt);
    assign silence_w = silence_limit(nom_w);

    assign in_band = (per_w >= short_limit(nom_w, 32'(ABS_MIN_PERIOD))) &&
                     (per_w <= long_limit(nom_w));
    assign duty_ok = duty_in_range(hi_w, per_w);
    assign lost    = (per_w >= silence_w);

    always_comb begin
        info_o.accepted    = rise & have_ref & in_band & duty_ok;
        info_o.rejected    = rise & ~(have_ref & in_band & duty_ok);
        info_o.lost        = lost & ~rise;
        info_o.low_timeout = ~pin_i & (low_w >= silence_w);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q      <= 1'b0;
            since_rise <= '1;
            hi_len     <= '0;
            low_cnt    <= '0;
            have_ref   <= 1'b0;
        end else begin
            pin_q <= pin_i;

            if (rise) begin
                since_rise <= CW'(1);
            end else if (since_rise != '1) begin
                since_rise <= since_rise + CW'(1);
            end

            if (fall) begin
                hi_len <= since_rise;
            end

            if (pin_i) begin
                low_cnt <= '0;
            end else if (low_cnt != '1) begin
                low_cnt <= low_cnt + CW'(1);
            end

            if (rise) begin
                have_ref <= 1'b1;
            end else if (lost) begin
                have_ref <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sms_mode_ctrl.sv
`timescale 1ns/1ps
module sms_mode_ctrl
    import sms_pkg::*;
#(
    parameter int SETTLE_CYCLES = 2500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_i,
    input  logic       osc_tick_i,
    input  edge_info_t info_i,
    output mode_e      mode_o,
    output logic       pulse_req_o
);

    localparam int SET_W = $clog2(SETTLE_CYCLES + 1);

    mode_e            mode_q;
    mode_e            mode_d;
    logic [SET_W-1:0] settle_cnt;
    logic             settle_done;
    logic             ext_req;
    logic             osc_req;

    assign settle_done = (32'(settle_cnt) + 32'd1) >= 32'(SETTLE_CYCLES);

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_STANDBY: begin
                if (pin_i) mode_d = MODE_FREE;
            end
            MODE_FREE: begin
                if (info_i.accepted) mode_d = MODE_SETTLE;
            end
            MODE_SETTLE: begin
                if (info_i.rejected || info_i.lost) begin
                    mode_d = MODE_FREE;
                end else if (info_i.accepted && settle_done) begin
                    mode_d = MODE_SYNC;
                end
            end
            MODE_SYNC: begin
                if (info_i.rejected || info_i.lost) mode_d = MODE_FREE;
            end
            default: mode_d = MODE_STANDBY;
        endcase
        if ((mode_q != MODE_STANDBY) && info_i.low_timeout) begin
            mode_d = MODE_STANDBY;
        end
    end

    // External edges own the pulse once the next mode is synchronized
    assign ext_req = info_i.accepted && (mode_d == MODE_SYNC);
    assign osc_req = osc_tick_i && !ext_req &&
                     ((mode_q == MODE_FREE) || (mode_q == MODE_SETTLE)) &&
                     (mode_d != MODE_STANDBY);
    assign pulse_req_o = ext_req | osc_req;
    assign mode_o      = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= MODE_STANDBY;
            settle_cnt <= '0;
        end else begin
            mode_q <= mode_d;
            if ((mode_d == MODE_SETTLE) && (mode_q != MODE_SETTLE)) begin
                settle_cnt <= '0;
            end else if ((mode_q == MODE_SETTLE) &&
                         (settle_cnt != SET_W'(SETTLE_CYCLES))) begin
                settle_cnt <= settle_cnt + SET_W'(1);
            end
        end
    end

endmodule

// File: rtl/sms_pulse_gate.sv
`timescale 1ns/1ps
module sms_pulse_gate
    import sms_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int ABS_MIN_PERIOD = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic [CNT_W-1:0] nom_i,
    output logic             pulse_o
);

    localparam int CW = CNT_W + 2;

    logic [CW-1:0] gap;
    logic          spacing_ok;
    logic          fire;

    assign spacing_ok = 32'(gap) >= short_limit(32'(nom_i), 32'(ABS_MIN_PERIOD));
    assign fire       = req_i & spacing_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap     <= '1;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= fire;
            if (fire) begin
                gap <= CW'(1);
            end else if (gap != '1) begin
                gap <= gap + CW'(1);
            end
        end
    end

endmodule

// File: rtl/sync_mode_sel.sv
`timescale 1ns/1ps
module sync_mode_sel
    import sms_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int SETTLE_CYCLES  = 2500,
    parameter int ABS_MIN_PERIOD = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_sync_i,
    input  logic             osc_tick_i,
    input  logic [CNT_W-1:0] nom_period_i,
    output logic             cycle_start_o,
    output logic             sync_active_o,
    output logic             standby_o,
    output logic             light_load_ok_o
);

    edge_info_t info;
    mode_e      mode;
    logic       pulse_req;

    sms_edge_meter #(
        .CNT_W          (CNT_W),
        .ABS_MIN_PERIOD (ABS_MIN_PERIOD)
    ) meter_i (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (en_sync_i),
        .nom_i  (nom_period_i),
        .info_o (info)
    );

    sms_mode_ctrl #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .pin_i       (en_sync_i),
        .osc_tick_i  (osc_tick_i),
        .info_i      (info),
        .mode_o      (mode),
        .pulse_req_o (pulse_req)
    );

    sms_pulse_gate #(
        .CNT_W          (CNT_W),
        .ABS_MIN_PERIOD (ABS_MIN_PERIOD)
    ) gate_i (
        .clk     (clk),
        .rst     (rst),
        .req_i   (pulse_req),
        .nom_i   (nom_period_i),
        .pulse_o (cycle_start_o)
    );

    assign sync_active_o   = (mode == MODE_SYNC);
    assign standby_o       = (mode == MODE_STANDBY);
    assign light_load_ok_o = (mode == MODE_FREE);

endmodule

// File: rtl/sync_mode_sel_chk.sv
`timescale 1ns/1ps
module sync_mode_sel_chk
    import sms_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int ABS_MIN_PERIOD = 36
) (
    input logic             clk,
    input logic             rst,
    input logic             en_sync_i,
    input logic [CNT_W-1:0] nom_period_i,
    input logic             cycle_start_o,
    input logic             sync_active_o,
    input logic             standby_o,
    input logic             light_load_ok_o
);

    logic        pin_q;
    logic [31:0] rise_gap;
    logic [31:0] pulse_gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q     <= 1'b0;
            rise_gap  <= '1;
            pulse_gap <= '1;
        end else begin
            pin_q <= en_sync_i;
            if (en_sync_i && !pin_q) rise_gap <= 32'd1;
            else if (rise_gap != '1) rise_gap <= rise_gap + 32'd1;
            if (cycle_start_o) pulse_gap <= 32'd1;
            else if (pulse_gap != '1) pulse_gap <= pulse_gap + 32'd1;
        end
    end

    // R11: pulses are one clock wide
    a_r11_one_cycle: assert property (@(posedge clk) disable iff (rst)
        cycle_start_o |=> !cycle_start_o);

    // R11: minimum spacing between pulses
    a_r11_spacing: assert property (@(posedge clk) disable iff (rst)
        cycle_start_o |-> (pulse_gap >= short_limit(32'(nom_period_i), 32'(ABS_MIN_PERIOD))));

    // R10: synchronization never outlives a 2*N silence
    a_r10_loss: assert property (@(posedge clk) disable iff (rst)
        sync_active_o |-> (rise_gap <= silence_limit(32'(nom_period_i))));

    // R2: standby is entered only from a low pin
    a_r2_standby_entry: assert property (@(posedge clk) disable iff (rst)
        (standby_o && !$past(standby_o)) |-> !$past(en_sync_i));

    // R2: no pulse while standing by
    a_r2_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        (standby_o && $past(standby_o)) |-> !cycle_start_o);

    // R7: synchronization starts on a pin rising edge
    a_r7_entry_on_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_active_o) |-> ($past(en_sync_i) && !$past(en_sync_i, 2)));

    // R9: light load is never allowed while synchronized
    a_r9_ll_off_in_sync: assert property (@(posedge clk) disable iff (rst)
        sync_active_o |-> !light_load_ok_o);

endmodule

bind sync_mode_sel sync_mode_sel_chk #(
    .CNT_W          (CNT_W),
    .ABS_MIN_PERIOD (ABS_MIN_PERIOD)
) chk_i (
    .clk             (clk),
    .rst             (rst),
    .en_sync_i       (en_sync_i),
    .nom_period_i    (nom_period_i),
    .cycle_start_o   (cycle_start_o),
    .sync_active_o   (sync_active_o),
    .standby_o       (standby_o),
    .light_load_ok_o (light_load_ok_o)
);

// File: tb/sync_mode_sel_tb_top.sv
`timescale 1ns/1ps
module sync_mode_sel_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int SETTLE     = 200;
    localparam int ABS_MIN    = 36;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en_r = 1'b0;
    logic             osc_r = 1'b0;
    logic [CNT_W-1:0] nom_r = 16'd100;
    logic             cycle_start;
    logic             sync_active;
    logic             standby;
    logic             ll_ok;

    int    cyc = 0;
    int    n_tests = 0;
    int    n_fail = 0;
    int    exp_q[$];
    string cur_req = "R1";
    logic  prev_pulse = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sync_mode_sel #(
        .CNT_W          (CNT_W),
        .SETTLE_CYCLES  (SETTLE),
        .ABS_MIN_PERIOD (ABS_MIN)
    ) dut_i (
        .clk             (clk),
        .rst             (rst),
        .en_sync_i       (en_r),
        .osc_tick_i      (osc_r),
        .nom_period_i    (nom_r),
        .cycle_start_o   (cycle_start),
        .sync_active_o   (sync_active),
        .standby_o       (standby),
        .light_load_ok_o (ll_ok)
    );

    // Monitor: pops expected pulse cycles and compares
    always @(negedge clk) begin
        if (!rst) begin
            if (cycle_start) begin
                n_tests++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL %s unexpected pulse: actual cycle=%0d expected=none", cur_req, cyc);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (e != cyc) begin
                        n_fail++;
                        $display("FAIL %s pulse cycle: actual=%0d expected=%0d", cur_req, cyc, e);
                    end
                end
                if (prev_pulse) begin
                    n_fail++;
                    $display("FAIL R11 pulse width: actual=2+ expected=1 at cycle %0d", cyc);
                end
            end
            prev_pulse = cycle_start;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_modes(input bit sb, input bit sa, input bit ll, input string req);
        check(standby == sb,     {req, " standby"},  int'(standby),     int'(sb));
        check(sync_active == sa, {req, " sync"},     int'(sync_active), int'(sa));
        check(ll_ok == ll,       {req, " lightld"},  int'(ll_ok),       int'(ll));
    endtask

    // Drive one cycle; an expected pulse appears after the next edge
    task automatic drive(input bit en, input bit osc, input bit expect_p);
        @(posedge clk);
        #(CLK_PERIOD/4);
        en_r  = en;
        osc_r = osc;
        if (expect_p) exp_q.push_back(cyc + 1);
    endtask

    task automatic hold(input bit en, input int n);
        for (int i = 0; i < n; i++) drive(en, 1'b0, 1'b0);
    endtask

    // One external clock period: low phase, then rising edge and high phase
    task automatic ext_period(input int lo, input int hi, input bit exp_rise,
                              input int tick_idx, input bit exp_tick, input bit tick_rise);
        for (int i = 0; i < lo; i++) drive(1'b0, (i == tick_idx), (i == tick_idx) && exp_tick);
        drive(1'b1, tick_rise, exp_rise);
        for (int i = 1; i < hi; i++) drive(1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        hold(1'b0, 5);
        chk_modes(1'b1, 1'b0, 1'b0, "R1");
        check(cycle_start == 1'b0, "R1 pulse", int'(cycle_start), 0);
        @(posedge clk);
        #(CLK_PERIOD/4);
        rst = 1'b0;

        // R2: ticks ignored in standby
        cur_req = "R2";
        for (int k = 0; k < 5; k++) begin
            hold(1'b0, 50);
            drive(1'b0, 1'b1, 1'b0);
        end
        hold(1'b0, 3);
        chk_modes(1'b1, 1'b0, 1'b0, "R2 standby-held");

        // R3: free running on oscillator ticks
        cur_req = "R3";
        drive(1'b1, 1'b0, 1'b0);
        hold(1'b1, 5);
        chk_modes(1'b0, 1'b0, 1'b1, "R3 free");
        for (int k = 0; k < 5; k++) begin
            hold(1'b1, 99);
            drive(1'b1, 1'b1, 1'b1);
        end

        // R11: a tick too close to the previous pulse is dropped
        cur_req = "R11";
        hold(1'b1, 99);
        drive(1'b1, 1'b1, 1'b1);
        hold(1'b1, 29);
        drive(1'b1, 1'b1, 1'b0);
        hold(1'b1, 80);
        drive(1'b1, 1'b1, 1'b1);
        hold(1'b1, 250);

        // R7/R9: lock on an 80-clock external clock
        cur_req = "R7";
        ext_period(40, 40, 1'b0, -1, 1'b0, 1'b0);   // arms
        ext_period(40, 40, 1'b0, -1, 1'b0, 1'b0);   // first accepted
        chk_modes(1'b0, 1'b0, 1'b0, "R9 settling");
        ext_period(40, 40, 1'b0, 5, 1'b1, 1'b0);    // osc still owns pulses
        ext_period(40, 40, 1'b0, -1, 1'b0, 1'b0);   // 160 clocks: not yet
        chk_modes(1'b0, 1'b0, 1'b0, "R7 not-yet");
        cur_req = "R8";
        ext_period(40, 40, 1'b1, -1, 1'b0, 1'b0);   // 240 clocks: sync
        chk_modes(1'b0, 1'b1, 1'b0, "R8 synced");
        ext_period(40, 40, 1'b1, -1, 1'b0, 1'b0);
        // R8: lone tick ignored; tick together with edge gives one pulse
        ext_period(40, 40, 1'b1, 20, 1'b0, 1'b0);
        ext_period(40, 40, 1'b1, -1, 1'b0, 1'b1);
        chk_modes(1'b0, 1'b1, 1'b0, "R8 still-synced");

        // R10/R4: too-fast edge drops sync without a pulse
        cur_req = "R10";
        ext_period(10, 25, 1'b0, -1, 1'b0, 1'b0);
        chk_modes(1'b0, 1'b0, 1'b1, "R10 reject-drop");
        cur_req = "R4";
        for (int k = 0; k < 6; k++) ext_period(25, 25, 1'b0, -1, 1'b0, 1'b0);
        chk_modes(1'b0, 1'b0, 1'b1, "R4 too-fast");
        for (int k = 0; k < 6; k++) ext_period(60, 60, 1'b0, -1, 1'b0, 1'b0);
        chk_modes(1'b0, 1'b0, 1'b1, "R4 too-slow");

        // R6: in-band period with 25% duty never locks
        cur_req = "R6";
        for (int k = 0; k < 6; k++) ext_period(60, 20, 1'b0, -1, 1'b0, 1'b0);
        chk_modes(1'b0, 1'b0, 1'b1, "R6 duty");

        // R5: with N=50 a 30-clock period is under the floor, 40 is accepted
        cur_req = "R5";
        nom_r = 16'd50;
        for (int k = 0; k < 10; k++) ext_period(15, 15, 1'b0, -1, 1'b0, 1'b0);
        chk_modes(1'b0, 1'b0, 1'b1, "R5 floor-reject");
        for (int k = 0; k < 3; k++) ext_period(20, 20, 1'b0, -1, 1'b0, 1'b0);
        chk_modes(1'b0, 1'b0, 1'b0, "R5 above-floor");
        nom_r = 16'd100;
        hold(1'b1, 300);
        chk_modes(1'b0, 1'b0, 1'b1, "R10 settle-lost");

        // R10: relock, then silence of 2*N clocks
        cur_req = "R10";
        for (int k = 0; k < 4; k++) ext_period(40, 40, 1'b0, -1, 1'b0, 1'b0);
        ext_period(40, 40, 1'b1, -1, 1'b0, 1'b0);
        ext_period(40, 40, 1'b1, -1, 1'b0, 1'b0);
        hold(1'b1, 110);
        chk_modes(1'b0, 1'b1, 1'b0, "R10 before-loss");
        hold(1'b1, 60);
        chk_modes(1'b0, 1'b0, 1'b1, "R10 after-loss");
        drive(1'b1, 1'b1, 1'b1);
        hold(1'b1, 3);

        // R2: long low enters standby, short low does not
        cur_req = "R2";
        hold(1'b0, 150);
        chk_modes(1'b0, 1'b0, 1'b1, "R2 short-low");
        hold(1'b0, 80);
        chk_modes(1'b1, 1'b0, 1'b0, "R2 long-low");
        drive(1'b0, 1'b1, 1'b0);
        hold(1'b0, 5);
        drive(1'b1, 1'b0, 1'b0);
        hold(1'b1, 3);
        chk_modes(1'b0, 1'b0, 1'b1, "R2 exit");

        hold(1'b1, 10);
        check(exp_q.size() == 0, "R8 missing pulses", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule